// File: doc/BRIEF.md
# Multi-Region Matrix Scratchpad Buffer

This block is the on-chip tensor store of a small neural-network accelerator. Its storage is split into seven equal regions, one each for network inputs, weights, biases, targets, activations, bias gradients and weight gradients. Every region has its own write pointer, so producers never supply an address: each stored element lands at the current pointer of the chosen region, and the pointer then moves on.

Two write paths feed the storage. The host port carries one 16-bit word and one valid bit per lane. The write-back port carries results computed on chip. Both paths use the same lane format. When both present data in the same cycle, the write-back path wins and the host is held off through a ready output.

A read engine streams a rectangular tile from one region onto the lanes. It is launched by a single-cycle start pulse together with a region select, a start address, a row count, a column count and a transpose flag. Elements are emitted in row-major order, or in column-major order when the transpose flag is set. Each lane carries one element per cycle and has its own valid bit.

Top module: `tensor_scratchpad`

## Requirements
- R1: While reset is high and in the first cycle after it, rd_busy is 0, every rd_valid lane is 0, rd_data is 0 and host_ready is 1. Reset also clears every region pointer to 0 and every stored word to 0.
- R2: A host write is accepted when host_ready is 1, at least one host_valid bit is set and host_region is 0 to 6. The valid lanes are stored in lane order (lane 0 first) at consecutive region-local positions, starting at that region's pointer. The pointer then advances by the number of valid lanes, wrapping modulo DEPTH.
- R3: A write-back with at least one wb_valid bit set and wb_region 0 to 6 stores its valid lanes into the region named by wb_region. It follows the same lane ordering and pointer rule as R2.
- R4: In any cycle with a wb_valid bit set, host_ready is 0. No host data is stored in that cycle, and the host path moves no pointer.
- R5: A write whose region select is 7 stores nothing and moves no pointer. This holds for both paths. A write-back to region 7 still holds off the host.
- R6: An rd_start pulse starts a read when rd_busy is 0, rd_region is 0 to 6, and rd_rows and rd_cols are both nonzero. rd_busy is 1 from the next cycle. Tile element (r, c) is the word at region-local position (rd_addr + r*rd_cols + c) mod DEPTH. Region codes are: 0 input, 1 weight, 2 bias, 3 target, 4 activation, 5 bias gradient, 6 weight gradient.
- R7: With rd_transpose at 0, element index i maps to r = i / rd_cols and c = i mod rd_cols. In beat b after the launch (b = 0 in the first busy cycle), lane k carries index b*LANES + k.
- R8: With rd_transpose at 1, element index i maps to c = i / rd_rows and r = i mod rd_rows. The lane and beat placement is the same as in R7.
- R9: Exactly rd_rows*rd_cols elements are emitted. In the last beat, lanes past the final element have valid 0. Every lane with valid 0 drives data 0. rd_busy falls after the last beat.
- R10: An rd_start with rd_region above 6, or with a zero row count or column count, starts nothing. rd_busy stays 0.
- R11: An rd_start pulse that arrives while rd_busy is 1 is ignored. The current tile completes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_data | input | LANES x 16 | Host write word per lane |
| host_valid | input | LANES | Host write valid per lane |
| host_region | input | 3 | Region written by the host |
| host_ready | output | 1 | Low while the write-back path holds the storage |
| wb_data | input | LANES x 16 | Write-back word per lane |
| wb_valid | input | LANES | Write-back valid per lane |
| wb_region | input | 3 | Region written by the write-back path |
| rd_start | input | 1 | Single-cycle read launch pulse |
| rd_transpose | input | 1 | 1 selects column-major emission |
| rd_region | input | 9 | Region to read |
| rd_addr | input | 16 | Region-local start address |
| rd_rows | input | 16 | Tile row count |
| rd_cols | input | 16 | Tile column count; also the row stride |
| rd_data | output | LANES x 16 | Streamed tile element per lane |
| rd_valid | output | LANES | Valid per streamed lane |
| rd_busy | output | 1 | Read engine active |

## Verification
The bench drives cycles in which the host and write-back paths collide. A design that let the host win, or stored both, would show host words in the region when it is read back later. Writes with only some lanes valid check the prefix placement. Writing past DEPTH checks the pointer wrap, and a start address near the region end checks the read wrap. A design that got these wrong would read back stale or misplaced words. Tiles with an odd element count, read in both orders, expose an engine that miscounts the final partial beat or swaps the divisor under transpose. Starts with region 9, a zero dimension, or arriving mid-tile must not disturb the stream. A design that honoured them would restart or corrupt the tile.

// File: rtl/scratch_pkg.sv
package scratch_pkg;

    localparam int WORD_W     = 16;
    localparam int DIM_W      = 16;
    localparam int REGION_CNT = 7;
    localparam int REGION_W   = 3;
    localparam int SEL_W      = 9;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [REGION_W-1:0] {
        RG_INPUT  = 3'd0,
        RG_WEIGHT = 3'd1,
        RG_BIAS   = 3'd2,
        RG_TARGET = 3'd3,
        RG_ACT    = 3'd4,
        RG_BGRAD  = 3'd5,
        RG_WGRAD  = 3'd6
    } region_e;

    typedef struct packed {
        logic [DIM_W-1:0] row;
        logic [DIM_W-1:0] col;
    } tile_pos_t;

    typedef struct packed {
        logic [REGION_W-1:0] region;
        logic                transpose;
        logic [DIM_W-1:0]    base;
        logic [DIM_W-1:0]    rows;
        logic [DIM_W-1:0]    cols;
    } tile_desc_t;

    function automatic logic sel_in_range(input logic [SEL_W-1:0] sel);
        return sel <= SEL_W'(RG_WGRAD);
    endfunction

    // Advance a tile cursor by one element in the selected order.
    function automatic tile_pos_t step_pos(input tile_pos_t p, input tile_desc_t d);
        tile_pos_t n;
        n = p;
        if (!d.transpose) begin
            if (p.col == d.cols - 1'b1) begin
                n.col = '0;
                n.row = p.row + 1'b1;
            end else begin
                n.col = p.col + 1'b1;
            end
        end else begin
            if (p.row == d.rows - 1'b1) begin
                n.row = '0;
                n.col = p.col + 1'b1;
            end else begin
                n.row = p.row + 1'b1;
            end
        end
        return n;
    endfunction

    function automatic logic [31:0] elem_offset(input tile_pos_t p, input tile_desc_t d);
        return 32'(d.base) + 32'(p.row) * 32'(d.cols) + 32'(p.col);
    endfunction

endpackage

// File: rtl/spad_wr_arbiter.sv
module spad_wr_arbiter
    import scratch_pkg::*;
#(
    parameter int LANES = 2,
    parameter int DEPTH = 32
)(
    input  logic                             clk,
    input  logic                             rst,
    input  logic [LANES-1:0][WORD_W-1:0]     host_data,
    input  logic [LANES-1:0]                 host_valid,
    input  logic [REGION_W-1:0]              host_region,
    output logic                             host_ready,
    input  logic [LANES-1:0][WORD_W-1:0]     wb_data,
    input  logic [LANES-1:0]                 wb_valid,
    input  logic [REGION_W-1:0]              wb_region,
    output logic [LANES-1:0]                 wr_en,
    output logic [LANES-1:0][REGION_W+$clog2(DEPTH)-1:0] wr_addr,
    output logic [LANES-1:0][WORD_W-1:0]     wr_data
);

    localparam int AW    = $clog2(DEPTH);
    localparam int CNT_W = $clog2(LANES + 1);

    logic                         use_wb;
    logic                         accept;
    logic [LANES-1:0]             sel_valid;
    logic [REGION_W-1:0]          sel_region;
    logic [CNT_W-1:0]             prefix [LANES+1];
    logic [AW-1:0]                base_ptr;
    logic [AW-1:0]                ptr_q [REGION_CNT];

    assign use_wb     = |wb_valid;
    assign host_ready = !use_wb;
    assign sel_valid  = use_wb ? wb_valid  : host_valid;
    assign sel_region = use_wb ? wb_region : host_region;
    assign wr_data    = use_wb ? wb_data   : host_data;
    assign accept     = (|sel_valid) && (sel_region < REGION_W'(REGION_CNT));
    assign base_ptr   = accept ? ptr_q[sel_region] : '0;

    always_comb begin
        prefix[0] = '0;
        for (int k = 0; k < LANES; k++) begin
            prefix[k+1] = prefix[k] + CNT_W'(sel_valid[k]);
        end
    end

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign wr_en[k]   = accept && sel_valid[k];
        assign wr_addr[k] = {sel_region, AW'(base_ptr + AW'(prefix[k]))};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < REGION_CNT; r++) begin
                ptr_q[r] <= '0;
            end
        end else if (accept) begin
            ptr_q[sel_region] <= base_ptr + AW'(prefix[LANES]);
        end
    end

endmodule

// File: rtl/spad_storage.sv
module spad_storage
    import scratch_pkg::*;
#(
    parameter int LANES = 2,
    parameter int DEPTH = 32
)(
    input  logic                                         clk,
    input  logic                                         rst,
    input  logic [LANES-1:0]                             wr_en,
    input  logic [LANES-1:0][REGION_W+$clog2(DEPTH)-1:0] wr_addr,
    input  logic [LANES-1:0][WORD_W-1:0]                 wr_data,
    input  logic [LANES-1:0][REGION_W+$clog2(DEPTH)-1:0] rd_addr,
    output logic [LANES-1:0][WORD_W-1:0]                 rd_data
);

    localparam int WORDS = REGION_CNT * DEPTH;

    word_t mem [WORDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < WORDS; i++) begin
                mem[i] <= '0;
            end
        end else begin
            for (int k = 0; k < LANES; k++) begin
                if (wr_en[k]) begin
                    mem[wr_addr[k]] <= wr_data[k];
                end
            end
        end
    end

    for (genvar k = 0; k < LANES; k++) begin : g_rd
        assign rd_data[k] = mem[rd_addr[k]];
    end

endmodule

// File: rtl/spad_tile_reader.sv
module spad_tile_reader
    import scratch_pkg::*;
#(
    parameter int LANES = 2,
    parameter int DEPTH = 32
)(
    input  logic                                         clk,
    input  logic                                         rst,
    input  logic                                         start,
    input  logic                                         transpose,
    input  logic [SEL_W-1:0]                             region_sel,
    input  logic [DIM_W-1:0]                             base,
    input  logic [DIM_W-1:0]                             rows,
    input  logic [DIM_W-1:0]                             cols,
    output logic                                         busy,
    output logic [LANES-1:0]                             lane_valid,
    output logic [LANES-1:0][REGION_W+$clog2(DEPTH)-1:0] lane_addr
);

    localparam int AW = $clog2(DEPTH);

    logic        busy_q;
    tile_desc_t  desc_q;
    tile_pos_t   cursor_q;
    logic [31:0] remain_q;
    tile_pos_t   pos [LANES+1];
    logic        launch;

    assign busy   = busy_q;
    assign launch = start && !busy_q && sel_in_range(region_sel)
                    && (rows != '0) && (cols != '0);

    assign pos[0] = cursor_q;
    for (genvar k = 0; k < LANES; k++) begin : g_chain
        assign pos[k+1]      = step_pos(pos[k], desc_q);
        assign lane_valid[k] = busy_q && (remain_q > 32'(k));
        assign lane_addr[k]  = {desc_q.region, AW'(elem_offset(pos[k], desc_q))};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q   <= 1'b0;
            desc_q   <= '0;
            cursor_q <= '0;
            remain_q <= '0;
        end else if (busy_q) begin
            if (remain_q <= 32'(LANES)) begin
                busy_q   <= 1'b0;
                remain_q <= '0;
            end else begin
                remain_q <= remain_q - 32'(LANES);
                cursor_q <= pos[LANES];
            end
        end else if (launch) begin
            busy_q           <= 1'b1;
            desc_q.region    <= REGION_W'(region_sel);
            desc_q.transpose <= transpose;
            desc_q.base      <= base;
            desc_q.rows      <= rows;
            desc_q.cols      <= cols;
            cursor_q         <= '0;
            remain_q         <= 32'(rows) * 32'(cols);
        end
    end

endmodule

// File: rtl/tensor_scratchpad.sv
module tensor_scratchpad
    import scratch_pkg::*;
#(
    parameter int LANES = 2,
    parameter int DEPTH = 32
)(
    input  logic                         clk,
    input  logic                         rst,
    input  logic [LANES-1:0][WORD_W-1:0] host_data,
    input  logic [LANES-1:0]             host_valid,
    input  logic [REGION_W-1:0]          host_region,
    output logic                         host_ready,
    input  logic [LANES-1:0][WORD_W-1:0] wb_data,
    input  logic [LANES-1:0]             wb_valid,
    input  logic [REGION_W-1:0]          wb_region,
    input  logic                         rd_start,
    input  logic                         rd_transpose,
    input  logic [SEL_W-1:0]             rd_region,
    input  logic [DIM_W-1:0]             rd_addr,
    input  logic [DIM_W-1:0]             rd_rows,
    input  logic [DIM_W-1:0]             rd_cols,
    output logic [LANES-1:0][WORD_W-1:0] rd_data,
    output logic [LANES-1:0]             rd_valid,
    output logic                         rd_busy
);

    localparam int IDX_W = REGION_W + $clog2(DEPTH);

    logic [LANES-1:0]              wr_en;
    logic [LANES-1:0][IDX_W-1:0]   wr_addr;
    logic [LANES-1:0][WORD_W-1:0]  wr_data;
    logic [LANES-1:0][IDX_W-1:0]   lane_addr;
    logic [LANES-1:0][WORD_W-1:0]  mem_rd;

    spad_wr_arbiter #(.LANES(LANES), .DEPTH(DEPTH)) u_arb (
        .clk(clk), .rst(rst),
        .host_data(host_data), .host_valid(host_valid), .host_region(host_region),
        .host_ready(host_ready),
        .wb_data(wb_data), .wb_valid(wb_valid), .wb_region(wb_region),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    spad_storage #(.LANES(LANES), .DEPTH(DEPTH)) u_mem (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(lane_addr), .rd_data(mem_rd)
    );

    spad_tile_reader #(.LANES(LANES), .DEPTH(DEPTH)) u_rd (
        .clk(clk), .rst(rst),
        .start(rd_start), .transpose(rd_transpose), .region_sel(rd_region),
        .base(rd_addr), .rows(rd_rows), .cols(rd_cols),
        .busy(rd_busy), .lane_valid(rd_valid), .lane_addr(lane_addr)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_out
        assign rd_data[k] = rd_valid[k] ? mem_rd[k] : '0;
    end

endmodule

// File: rtl/tensor_scratchpad_checker.sv
module tensor_scratchpad_checker #(
    parameter int LANES = 2
)(
    input logic             clk,
    input logic             rst,
    input logic             rd_start,
    input logic [8:0]       rd_region,
    input logic [15:0]      rd_rows,
    input logic [15:0]      rd_cols,
    input logic             rd_busy,
    input logic [LANES-1:0] rd_valid
);

    logic [LANES-1:0] valid_plus;
    assign valid_plus = rd_valid + 1'b1;

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !rd_busy |-> (rd_valid == '0));

    assert_lane0_live_R7: assert property (@(posedge clk) disable iff (rst)
        rd_busy |-> rd_valid[0]);

    // R9: valid lanes always form a contiguous run starting at lane 0
    assert_valid_contig_R9: assert property (@(posedge clk) disable iff (rst)
        (valid_plus & rd_valid) == '0);

    assert_bad_region_R10: assert property (@(posedge clk) disable iff (rst)
        (rd_start && !rd_busy && (rd_region > 9'd6)) |=> !rd_busy);

    assert_zero_dim_R10: assert property (@(posedge clk) disable iff (rst)
        (rd_start && !rd_busy && ((rd_rows == '0) || (rd_cols == '0))) |=> !rd_busy);

    assert_launch_R6: assert property (@(posedge clk) disable iff (rst)
        (rd_start && !rd_busy && (rd_region <= 9'd6) && (rd_rows != '0) && (rd_cols != '0))
        |=> rd_busy);

endmodule

bind tensor_scratchpad tensor_scratchpad_checker #(.LANES(LANES)) u_chk (
    .clk(clk), .rst(rst), .rd_start(rd_start), .rd_region(rd_region),
    .rd_rows(rd_rows), .rd_cols(rd_cols), .rd_busy(rd_busy), .rd_valid(rd_valid)
);

// File: tb/tb_tensor_scratchpad.sv
module tb_tensor_scratchpad;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int LANES = 2;
    localparam int DEPTH = 32;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic                   rst;
    logic [LANES-1:0][15:0] host_data;
    logic [LANES-1:0]       host_valid;
    logic [2:0]             host_region;
    logic                   host_ready;
    logic [LANES-1:0][15:0] wb_data;
    logic [LANES-1:0]       wb_valid;
    logic [2:0]             wb_region;
    logic                   rd_start;
    logic                   rd_transpose;
    logic [8:0]             rd_region;
    logic [15:0]            rd_addr;
    logic [15:0]            rd_rows;
    logic [15:0]            rd_cols;
    logic [LANES-1:0][15:0] rd_data;
    logic [LANES-1:0]       rd_valid;
    logic                   rd_busy;

    tensor_scratchpad #(.LANES(LANES), .DEPTH(DEPTH)) dut (
        .clk(clk), .rst(rst),
        .host_data(host_data), .host_valid(host_valid), .host_region(host_region),
        .host_ready(host_ready),
        .wb_data(wb_data), .wb_valid(wb_valid), .wb_region(wb_region),
        .rd_start(rd_start), .rd_transpose(rd_transpose), .rd_region(rd_region),
        .rd_addr(rd_addr), .rd_rows(rd_rows), .rd_cols(rd_cols),
        .rd_data(rd_data), .rd_valid(rd_valid), .rd_busy(rd_busy)
    );

    int    checks = 0;
    int    fails  = 0;
    string cur_req = "R1";
    bit    finished = 1'b0;

    // behavioural reference model
    logic [15:0] m_mem [7][DEPTH];
    int          m_ptr [7];
    bit          m_busy, m_tr;
    int          m_reg, m_base, m_rows, m_cols, m_n, m_emit;

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int r = 0; r < 7; r++) begin
            m_ptr[r] = 0;
            for (int a = 0; a < DEPTH; a++) m_mem[r][a] = 16'h0;
        end
        m_busy = 0; m_tr = 0; m_reg = 0; m_base = 0;
        m_rows = 0; m_cols = 0; m_n = 0; m_emit = 0;
    endtask

    task automatic model_store(input int r, input logic [LANES-1:0] v,
                               input logic [LANES-1:0][15:0] d);
        for (int k = 0; k < LANES; k++) begin
            if (v[k]) begin
                m_mem[r][m_ptr[r]] = d[k];
                m_ptr[r] = (m_ptr[r] + 1) % DEPTH;
            end
        end
    endtask

    task automatic model_edge();
        if (wb_valid != '0) begin
            if (wb_region < 3'd7) model_store(int'(wb_region), wb_valid, wb_data);
        end else if (host_valid != '0 && host_region < 3'd7) begin
            model_store(int'(host_region), host_valid, host_data);
        end
        if (m_busy) begin
            m_emit += LANES;
            if (m_emit >= m_n) m_busy = 0;
        end else if (rd_start && rd_region < 9'd7 && rd_rows != 0 && rd_cols != 0) begin
            m_busy = 1; m_emit = 0;
            m_reg = int'(rd_region); m_tr = rd_transpose; m_base = int'(rd_addr);
            m_rows = int'(rd_rows); m_cols = int'(rd_cols); m_n = m_rows * m_cols;
        end
    endtask

    task automatic compare();
        int idx, r, c, a;
        bit v;
        logic [15:0] d;
        check("host_ready", 32'(host_ready), 32'(wb_valid == '0));
        check("rd_busy", 32'(rd_busy), 32'(m_busy));
        for (int k = 0; k < LANES; k++) begin
            idx = m_emit + k;
            v = m_busy && (idx < m_n);
            d = 16'h0;
            if (v) begin
                if (m_tr) begin c = idx / m_rows; r = idx % m_rows; end
                else      begin r = idx / m_cols; c = idx % m_cols; end
                a = (m_base + r * m_cols + c) % DEPTH;
                d = m_mem[m_reg][a];
            end
            check($sformatf("rd_valid[%0d]", k), 32'(rd_valid[k]), 32'(v));
            check($sformatf("rd_data[%0d]", k), 32'(rd_data[k]), 32'(d));
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        if (rst) model_reset();
        else     model_edge();
        @(negedge clk);
        compare();
    endtask

    task automatic host_wr(input int r, input logic [LANES-1:0] v, input logic [15:0] d0, input logic [15:0] d1);
        host_region = 3'(r); host_valid = v; host_data[0] = d0; host_data[1] = d1;
        cyc();
        host_valid = '0;
    endtask

    task automatic wb_wr(input int r, input logic [LANES-1:0] v, input logic [15:0] d0, input logic [15:0] d1);
        wb_region = 3'(r); wb_valid = v; wb_data[0] = d0; wb_data[1] = d1;
        cyc();
        wb_valid = '0;
    endtask

    task automatic pulse_start(input int r, input bit tr, input int base, input int rows, input int cols);
        rd_region = 9'(r); rd_transpose = tr; rd_addr = 16'(base);
        rd_rows = 16'(rows); rd_cols = 16'(cols); rd_start = 1'b1;
        cyc();
        rd_start = 1'b0;
    endtask

    task automatic read_tile(input int r, input bit tr, input int base, input int rows, input int cols);
        pulse_start(r, tr, base, rows, cols);
        while (m_busy) cyc();
        cyc();
    endtask

    initial begin
        #(20ns * 100000);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; host_data = '0; host_valid = '0; host_region = '0;
        wb_data = '0; wb_valid = '0; wb_region = '0; rd_start = 1'b0;
        rd_transpose = 1'b0; rd_region = '0; rd_addr = '0; rd_rows = '0; rd_cols = '0;
        model_reset();

        cur_req = "R1";
        cyc(); cyc();
        rst = 1'b0;
        cyc();

        cur_req = "R2";
        for (int i = 0; i < 8; i++) host_wr(1, 2'b11, 16'h1000 + 16'(2*i), 16'h1001 + 16'(2*i));
        for (int i = 0; i < 3; i++) host_wr(1, 2'b10, 16'h1100 + 16'(i), 16'h1180 + 16'(i));
        for (int i = 0; i < 3; i++) host_wr(1, 2'b01, 16'h1200 + 16'(i), 16'h1280 + 16'(i));

        cur_req = "R7";
        read_tile(1, 1'b0, 0, 4, 5);
        cur_req = "R8";
        read_tile(1, 1'b1, 0, 4, 5);
        cur_req = "R6";
        read_tile(1, 1'b0, 3, 2, 3);

        cur_req = "R3";
        for (int i = 0; i < 6; i++) wb_wr(4, 2'b11, 16'h4400 + 16'(i), 16'h4480 + 16'(i));
        wb_wr(4, 2'b10, 16'h0, 16'h44FF);
        read_tile(4, 1'b0, 0, 3, 4);

        cur_req = "R4";
        for (int i = 0; i < 4; i++) begin
            host_region = 3'd0; host_valid = 2'b11;
            host_data[0] = 16'hBAD0; host_data[1] = 16'hBAD1;
            wb_wr(0, (i == 2) ? 2'b01 : 2'b11, 16'h4000 + 16'(i), 16'h4010 + 16'(i));
        end
        host_valid = '0;
        host_wr(0, 2'b11, 16'h0A00, 16'h0A01);
        read_tile(0, 1'b0, 0, 1, 12);

        cur_req = "R5";
        host_wr(7, 2'b11, 16'hDEAD, 16'hDEAE);
        wb_wr(7, 2'b11, 16'hDEAF, 16'hDEA0);
        host_region = 3'd3; host_valid = 2'b11; host_data[0] = 16'hBEEF; host_data[1] = 16'hBEEE;
        wb_wr(7, 2'b01, 16'hDEA1, 16'hDEA2);
        host_valid = '0;
        host_wr(3, 2'b01, 16'h3300, 16'h0);
        for (int r = 0; r < 7; r++) read_tile(r, 1'b0, 0, 1, DEPTH);

        cur_req = "R2";
        for (int i = 0; i < 20; i++) host_wr(2, 2'b11, 16'h2000 + 16'(2*i), 16'h2001 + 16'(2*i));
        read_tile(2, 1'b0, 0, 4, 8);

        cur_req = "R9";
        read_tile(2, 1'b0, 0, 3, 3);
        read_tile(2, 1'b1, 5, 3, 3);
        read_tile(2, 1'b0, 30, 2, 3);
        read_tile(1, 1'b0, 7, 1, 1);

        cur_req = "R10";
        pulse_start(9, 1'b0, 0, 2, 2);
        cyc();
        pulse_start(7, 1'b0, 0, 2, 2);
        cyc();
        pulse_start(2, 1'b0, 0, 0, 4);
        cyc();
        pulse_start(2, 1'b1, 0, 4, 0);
        cyc();

        cur_req = "R11";
        pulse_start(2, 1'b0, 1, 2, 4);
        cyc();
        pulse_start(1, 1'b1, 0, 5, 5);
        while (m_busy) cyc();
        cyc();

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule